// File: doc/BRIEF.md
# ECC Error Status Register with Diagnostic Lock

This block records data-path error events for a two-cycle data transfer. Each clock it accepts per-cycle strobes for correctable ECC, uncorrectable ECC, data-valid tag-control and tag-control errors, together with a read/write indicator and one ECC syndrome per data cycle. Five sticky error bits accumulate what was seen. Two syndrome fields hold the syndromes of the most significant ECC error recorded so far. A later uncorrectable error therefore replaces syndromes that were captured for a correctable one.

Software reads the whole register through one read-data word. Writing a one to an error bit clears that bit. A lock-enable bit can be read and written. When lock-enable is set, the first error freezes the register, which is useful for diagnostics. The register is released when software clears all error bits or clears lock-enable.

Top module: `ecc_err_status`

## Requirements
- R1: After reset, every read-data bit is 0 and `locked_o` is 0.
- R2: Error bits are assigned as follows: bit 0 for correctable ECC when `wr_i`=0, bit 1 for correctable ECC when `wr_i`=1, bit 2 for uncorrectable ECC, bit 3 for data-valid tag-control error, bit 4 for tag-control error. A strobe in any data cycle sets its bit on the next clock edge.
- R3: While unlocked, error bits are sticky and accumulate across transfers.
- R4: A software write clears each error bit whose `sw_wdata_i` bit is 1 and leaves each error bit whose `sw_wdata_i` bit is 0 unchanged.
- R5: While unlocked, a new error that arrives in the same clock as a software clear of its bit leaves that bit set.
- R6: Lock-enable is read-data bit 5. A software write loads it from `sw_wdata_i[5]`.
- R7: With lock-enable set, the transfer that produces the first error is recorded in full. From then on `locked_o` is 1, and no error bit or syndrome changes because of new errors.
- R8: The lock is released, and recording resumes, when software clears all error bits or clears lock-enable. Lock-enable alone does not set `locked_o`.
- R9: Read-data bits [15:8] hold the cycle-0 syndrome and bits [23:16] hold the cycle-1 syndrome. An ECC error whose significance (uncorrectable above correctable) is equal to or higher than the recorded one overwrites both fields. Tag-control errors never update them.
- R10: An ECC error of lower significance than the recorded one leaves both syndrome fields unchanged.
- R11: Syndrome fields and read-data bits 7:6 ignore software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| corr_i | input | 2 | Correctable ECC strobe, one per data cycle |
| unc_i | input | 2 | Uncorrectable ECC strobe, one per data cycle |
| dvt_i | input | 2 | Data-valid tag-control error strobe, one per data cycle |
| tag_i | input | 2 | Tag-control error strobe, one per data cycle |
| wr_i | input | 1 | Transfer is a write (1) or a read (0) |
| syn_i | input | 16 | Syndromes; [7:0] for cycle 0, [15:8] for cycle 1 |
| sw_we_i | input | 1 | Software register write strobe |
| sw_wdata_i | input | 24 | Software write data |
| rdata_o | output | 24 | Register contents |
| locked_o | output | 1 | Register is frozen by the diagnostic lock |

## Verification
A software write and a hardware error event can land on the same clock edge. This matters in two places: a write-one-to-clear against a fresh strobe of the same bit, and a lock release against an incoming error. The bench drives both in a single cycle from one task. It checks that a clear without a concurrent error leaves the bit at zero. It checks that an error which coincides with a clear stays set and brings its syndromes with it. It also checks that a frozen register ignores errors until the release write has taken effect, and then relocks on the next error.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_COR  = 2'd1,
    LVL_UNC  = 2'd2
  } sev_e;

  localparam int unsigned N_ERR    = 5;
  localparam int unsigned E_CRD    = 0;
  localparam int unsigned E_CWR    = 1;
  localparam int unsigned E_UNC    = 2;
  localparam int unsigned E_DVT    = 3;
  localparam int unsigned E_TAG    = 4;
  localparam int unsigned LOCK_POS = 5;
endpackage

// File: rtl/ecc_cyc_classify.sv
module ecc_cyc_classify
  import ecc_err_pkg::*;
(
  input  logic             corr_i,
  input  logic             unc_i,
  input  logic             dvt_i,
  input  logic             tag_i,
  input  logic             wr_i,
  output logic [N_ERR-1:0] set_o
);
  always_comb begin
    set_o        = '0;
    set_o[E_CRD] = corr_i & ~wr_i;
    set_o[E_CWR] = corr_i & wr_i;
    set_o[E_UNC] = unc_i;
    set_o[E_DVT] = dvt_i;
    set_o[E_TAG] = tag_i;
  end
endmodule

// File: rtl/ecc_syn_track.sv
module ecc_syn_track
  import ecc_err_pkg::*;
#(
  parameter int unsigned NCYC  = 2,
  parameter int unsigned SYN_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hold_i,
  input  logic [NCYC-1:0]       cor_i,
  input  logic [NCYC-1:0]       unc_i,
  input  sev_e                  rec_lvl_i,
  input  logic [NCYC*SYN_W-1:0] syn_i,
  output logic [NCYC*SYN_W-1:0] syn_o
);
  sev_e                  new_lvl;
  logic                  cap;
  logic [NCYC*SYN_W-1:0] syn_q;

  always_comb begin
    if (|unc_i)      new_lvl = LVL_UNC;
    else if (|cor_i) new_lvl = LVL_COR;
    else             new_lvl = LVL_NONE;
    cap = !hold_i && (new_lvl != LVL_NONE) && (new_lvl >= rec_lvl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  syn_q <= '0;
    else if (cap) syn_q <= syn_i;
  end

  assign syn_o = syn_q;

  // R7
  hold_syn_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(syn_q));

  // R10
  lower_sev_keeps_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_lvl < rec_lvl_i) |=> $stable(syn_q));
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_err_pkg::*;
#(
  parameter int unsigned NCYC    = 2,
  parameter int unsigned SYN_W   = 8,
  parameter int unsigned SYN_LSB = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NCYC-1:0]               corr_i,
  input  logic [NCYC-1:0]               unc_i,
  input  logic [NCYC-1:0]               dvt_i,
  input  logic [NCYC-1:0]               tag_i,
  input  logic                          wr_i,
  input  logic [NCYC*SYN_W-1:0]         syn_i,
  input  logic                          sw_we_i,
  input  logic [SYN_LSB+NCYC*SYN_W-1:0] sw_wdata_i,
  output logic [SYN_LSB+NCYC*SYN_W-1:0] rdata_o,
  output logic                          locked_o
);
  localparam int unsigned REG_W = SYN_LSB + NCYC * SYN_W;

  logic [NCYC-1:0][N_ERR-1:0] cyc_set;
  logic [N_ERR-1:0]           hw_set, eff_set, clr_mask;
  logic [N_ERR-1:0]           err_q;
  logic                       lock_en_q, locked;
  sev_e                       rec_lvl;
  logic [NCYC*SYN_W-1:0]      syn;
  logic                       unused_wdata;

  for (genvar c = 0; c < NCYC; c++) begin : g_cyc
    ecc_cyc_classify u_cls (
      .corr_i (corr_i[c]),
      .unc_i  (unc_i[c]),
      .dvt_i  (dvt_i[c]),
      .tag_i  (tag_i[c]),
      .wr_i   (wr_i),
      .set_o  (cyc_set[c])
    );
  end

  always_comb begin
    hw_set = '0;
    for (int c = 0; c < NCYC; c++) hw_set |= cyc_set[c];
  end

  assign locked   = lock_en_q && (err_q != '0);
  assign eff_set  = locked ? '0 : hw_set;
  assign clr_mask = sw_we_i ? sw_wdata_i[N_ERR-1:0] : '0;

  always_comb begin
    if (err_q[E_UNC])                     rec_lvl = LVL_UNC;
    else if (err_q[E_CRD] | err_q[E_CWR]) rec_lvl = LVL_COR;
    else                                  rec_lvl = LVL_NONE;
  end

  // new error wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= '0;
      lock_en_q <= 1'b0;
    end else begin
      err_q <= (err_q & ~clr_mask) | eff_set;
      if (sw_we_i) lock_en_q <= sw_wdata_i[LOCK_POS];
    end
  end

  ecc_syn_track #(.NCYC(NCYC), .SYN_W(SYN_W)) u_syn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (locked),
    .cor_i     (corr_i),
    .unc_i     (unc_i),
    .rec_lvl_i (rec_lvl),
    .syn_i     (syn_i),
    .syn_o     (syn)
  );

  always_comb begin
    rdata_o                           = '0;
    rdata_o[N_ERR-1:0]                = err_q;
    rdata_o[LOCK_POS]                 = lock_en_q;
    rdata_o[SYN_LSB +: NCYC*SYN_W]    = syn;
  end

  assign locked_o     = locked;
  assign unused_wdata = ^{sw_wdata_i[REG_W-1:LOCK_POS+1]};

  // R7
  locked_no_new_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> ((err_q & ~$past(err_q)) == '0));

  // R5
  unc_sets_when_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked && (|unc_i)) |=> err_q[E_UNC]);

  // R4
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> ((err_q & $past(sw_wdata_i[N_ERR-1:0] & ~eff_set)) == '0));

  // R6
  lock_en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> (rdata_o[LOCK_POS] == $past(sw_wdata_i[LOCK_POS])));
endmodule

// File: tb/tb_ecc_err_status.sv
module tb_ecc_err_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  corr = '0, unc = '0, dvt = '0, tag = '0;
  logic        wr = 1'b0;
  logic [15:0] syn = '0;
  logic        we = 1'b0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        locked;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ecc_err_status dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .corr_i     (corr),
    .unc_i      (unc),
    .dvt_i      (dvt),
    .tag_i      (tag),
    .wr_i       (wr),
    .syn_i      (syn),
    .sw_we_i    (we),
    .sw_wdata_i (wdata),
    .rdata_o    (rdata),
    .locked_o   (locked)
  );

  task automatic chk(string req, logic [23:0] exp_rd, logic exp_lk);
    checks++;
    if (rdata !== exp_rd || locked !== exp_lk) begin
      errors++;
      $display("FAIL %s: rdata=%h locked=%b expected rdata=%h locked=%b",
               req, rdata, locked, exp_rd, exp_lk);
    end
  endtask

  // one clock of stimulus; result sampled 1 ns after the edge
  task automatic xact(logic [1:0] c, logic [1:0] u, logic [1:0] d, logic [1:0] t,
                      logic w, logic [15:0] s, logic swe, logic [23:0] swd);
    @(negedge clk);
    corr = c; unc = u; dvt = d; tag = t; wr = w; syn = s; we = swe; wdata = swd;
    @(posedge clk);
    #1;
    corr = '0; unc = '0; dvt = '0; tag = '0; wr = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic sw_write(logic [23:0] d);
    xact(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0, 1'b1, d);
  endtask

  task automatic t_reset;
    chk("R1 reset", 24'h000000, 1'b0);
  endtask

  task automatic t_classify;
    xact(2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 16'h2211, 1'b0, 0);
    chk("R2 corr read", 24'h221101, 1'b0);
    sw_write(24'h1F);
    chk("R4 clear all", 24'h221100, 1'b0);
    xact(2'b01, 2'b00, 2'b00, 2'b00, 1'b1, 16'h4433, 1'b0, 0);
    chk("R2 corr write", 24'h443302, 1'b0);
    sw_write(24'h1F);
    xact(2'b00, 2'b00, 2'b01, 2'b10, 1'b0, 16'h6655, 1'b0, 0);
    chk("R2/R9 dvt+tag, no syndrome update", 24'h443318, 1'b0);
    sw_write(24'h1F);
    xact(2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 16'h8877, 1'b0, 0);
    chk("R2 uncorrectable", 24'h887704, 1'b0);
    sw_write(24'h1F);
  endtask

  task automatic t_accum;
    xact(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0102, 1'b0, 0);
    xact(2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 16'h0304, 1'b0, 0);
    chk("R3 accumulate tag", 24'h010211, 1'b0);
    xact(2'b10, 2'b00, 2'b00, 2'b00, 1'b1, 16'h0506, 1'b0, 0);
    chk("R3/R9 equal level overwrites", 24'h050613, 1'b0);
    sw_write(24'h1F);
    chk("R4 clear all", 24'h050600, 1'b0);
  endtask

  task automatic t_w1c;
    xact(2'b01, 2'b00, 2'b00, 2'b10, 1'b0, 16'h0A0B, 1'b0, 0);
    chk("R2 corr+tag", 24'h0A0B11, 1'b0);
    sw_write(24'h000010);
    chk("R4 clear only tag", 24'h0A0B01, 1'b0);
    sw_write(24'h000000);
    chk("R4 zero write keeps", 24'h0A0B01, 1'b0);
    sw_write(24'h1F);
  endtask

  task automatic t_set_beats_clear;
    xact(2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 16'h0C0D, 1'b0, 0);
    xact(2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 16'h0E0F, 1'b1, 24'h1F);
    chk("R5 set beats clear", 24'h0E0F04, 1'b0);
    sw_write(24'h1F);
    chk("R5 clear afterwards", 24'h0E0F00, 1'b0);
  endtask

  task automatic t_syn_overwrite;
    xact(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 16'h1122, 1'b0, 0);
    xact(2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 16'h3344, 1'b0, 0);
    chk("R9 unc overwrites corr syndromes", 24'h334405, 1'b0);
    sw_write(24'h1F);
  endtask

  task automatic t_syn_keep;
    xact(2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 16'h5566, 1'b0, 0);
    xact(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 16'h7788, 1'b0, 0);
    chk("R10 lower level keeps syndromes", 24'h556605, 1'b0);
    sw_write(24'h1F);
  endtask

  task automatic t_ro_and_lock_en;
    sw_write(24'hFFFFC0);
    chk("R11 syndromes read-only", 24'h556600, 1'b0);
    sw_write(24'h000020);
    chk("R6/R8 lock enable alone", 24'h556620, 1'b0);
  endtask

  task automatic t_lock_freeze;
    xact(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 16'h99AA, 1'b0, 0);
    chk("R7 first error captured", 24'h99AA21, 1'b1);
    xact(2'b00, 2'b11, 2'b00, 2'b00, 1'b0, 16'hBBCC, 1'b0, 0);
    chk("R7 unc ignored while locked", 24'h99AA21, 1'b1);
    xact(2'b00, 2'b00, 2'b01, 2'b01, 1'b0, 16'h0000, 1'b0, 0);
    chk("R7 tag ignored while locked", 24'h99AA21, 1'b1);
  endtask

  task automatic t_release_bits;
    sw_write(24'h000021);
    chk("R8 release by clearing bits", 24'h99AA20, 1'b0);
    xact(2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 16'hDDEE, 1'b0, 0);
    chk("R7 relock on next error", 24'hDDEE24, 1'b1);
  endtask

  task automatic t_release_lock_en;
    sw_write(24'h000000);
    chk("R8 release by lock enable", 24'hDDEE04, 1'b0);
    xact(2'b00, 2'b00, 2'b00, 2'b10, 1'b0, 16'h0000, 1'b0, 0);
    chk("R8 recording resumes", 24'hDDEE14, 1'b0);
    xact(2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 16'h1234, 1'b0, 0);
    chk("R10 corr after unc", 24'hDDEE15, 1'b0);
    sw_write(24'h1F);
    chk("R4 final clear", 24'hDDEE00, 1'b0);
  endtask

  initial begin
    #35;
    t_reset();
    rst_n = 1'b1;
    t_classify();
    t_accum();
    t_w1c();
    t_set_beats_clear();
    t_syn_overwrite();
    t_syn_keep();
    t_ro_and_lock_en();
    t_lock_freeze();
    t_release_bits();
    t_release_lock_en();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule